// File: doc/BRIEF.md
# Serial Port FIFO Pair with Reset Control

This block holds the transmit and receive byte FIFOs of a UART-style serial port. It also holds the small control and status state that decides what each kind of reset does. Three stored control bits shape the resets.

- **Channel run bit.** Writing it to 0 resets both channels. Software then writes it back to 1.
- **Transmit run bit and receive run bit.** While one of these is 0, that FIFO's pointers are held at zero.

A channel reset zeroes the pointers of both FIFOs and clears the interrupt flags and the overflow flag. It leaves the stored control bits, the thresholds, the stored bytes and the per-entry error tags as they are. No reset erases the storage. Old entries only become unreachable because the pointers restart.

The serial side is a pair of simple byte handshakes:
- The serialiser pops bytes from the transmit FIFO.
- The deserialiser pushes received bytes into the receive FIFO, each with a framing tag and a parity tag.

The bus side pushes transmit bytes and pops received bytes. It writes the control bits through a per-bit write mask, writes the two thresholds, and clears the flags with write-one-to-clear strobes. `DEPTH` must be a power of two.

Top module: `uart_fifo_rstctl`

## Requirements
- R1: Each FIFO returns bytes in push order. The level is the number of stored entries, and the head output shows the oldest entry. A pop while the FIFO is empty is ignored and the level stays 0.
- R2: `chan_run` is set to 1 by hardware reset. Writing bit 0 of `ctl_d` with `ctl_we[0]` set stores it. While it reads 0, the pointers of both FIFOs are held at zero from the next cycle on: both levels read 0 and both empty outputs read 1. Writing it back to 1 ends the hold.
- R3: While `chan_run` is 0, `tx_int`, `rx_int` and `rx_ovf` are cleared.
- R4: A write that changes only bit 0 leaves `tx_run` (bit 1) and `rx_run` (bit 2) unchanged. It also leaves the thresholds unchanged.
- R5: While `rx_run` (or `tx_run`) is 0, that FIFO's pointers are held at zero, its level reads 0 and it reads empty.
- R6: A push to a FIFO whose pointers are held by either reset is ignored: its level stays 0 and no overflow is flagged.
- R7: No reset erases storage. The head outputs always show the slot at the read pointer, including the receive framing tag (`rx_head_fe`) and parity tag (`rx_head_pe`). After a reset they show the old contents of slot 0 until a new push overwrites that slot.
- R8: A receive push while the receive FIFO holds `DEPTH` entries is dropped and sets `rx_ovf`. The flag stays set until a channel reset or a write with `clr_w1c[2]` set; the clear does not move the pointers.
- R9: `tx_int` sets one cycle after `tx_level <= tx_thr`, and `rx_int` sets one cycle after `rx_level >= rx_thr`. They are cleared by `clr_w1c[0]` and `clr_w1c[1]`, but a true set condition in the same cycle wins over the clear.
- R10: Hardware reset gives empty FIFOs, all three run bits at 1, `tx_thr` = 0, `rx_thr` = `DEPTH`, and all flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| ctl_we | input | 3 | Per-bit write mask for the control bits |
| ctl_d | input | 3 | Control write data: bit0 channel run, bit1 tx run, bit2 rx run |
| thr_we | input | 1 | Writes both thresholds |
| tx_thr_d | input | AW+1 | Transmit threshold write data |
| rx_thr_d | input | AW+1 | Receive threshold write data |
| clr_w1c | input | 3 | Flag clear strobes: bit0 tx_int, bit1 rx_int, bit2 rx_ovf |
| chan_run | output | 1 | Stored channel run bit (0 = channel reset) |
| tx_run | output | 1 | Stored transmit FIFO run bit |
| rx_run | output | 1 | Stored receive FIFO run bit |
| tx_push | input | 1 | Bus pushes a transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| tx_pop | input | 1 | Serialiser pops a transmit byte |
| tx_head | output | 8 | Transmit slot at the read pointer |
| tx_level | output | AW+1 | Transmit fill level |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_push | input | 1 | Deserialiser pushes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_fe_in | input | 1 | Framing error tag of the received byte |
| rx_pe_in | input | 1 | Parity error tag of the received byte |
| rx_pop | input | 1 | Bus pops a received byte |
| rx_head | output | 8 | Receive slot data at the read pointer |
| rx_head_fe | output | 1 | Framing tag of that slot |
| rx_head_pe | output | 1 | Parity tag of that slot |
| rx_level | output | AW+1 | Receive fill level |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_int | output | 1 | Transmit threshold flag |
| rx_int | output | 1 | Receive threshold flag |
| rx_ovf | output | 1 | Receive overflow flag |

## Verification
The bound checker watches several rules on every cycle:
- the levels never exceed the depth;
- a stored zero in any run bit empties the affected FIFOs on the next cycle;
- a zero channel run bit leaves all three flags cleared;
- a write of the channel bit alone leaves the per-FIFO bits untouched;
- a push into a full receive FIFO always raises the overflow flag.

Only the bench scenarios can show three further behaviours: that the storage and its error tags survive both resets and show up again at the head outputs, that dropped pushes never overwrite a slot, and that the flags obey the ordering between the threshold condition and the write-one-to-clear strobes.

// File: rtl/uart_fifo_rstctl.sv
module uart_fifo_rstctl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ctl_we,
  input  logic [2:0]    ctl_d,
  input  logic          thr_we,
  input  logic [LW-1:0] tx_thr_d,
  input  logic [LW-1:0] rx_thr_d,
  input  logic [2:0]    clr_w1c,
  output logic          chan_run,
  output logic          tx_run,
  output logic          rx_run,
  input  logic          tx_push,
  input  logic [7:0]    tx_wdata,
  input  logic          tx_pop,
  output logic [7:0]    tx_head,
  output logic [LW-1:0] tx_level,
  output logic          tx_empty,
  input  logic          rx_push,
  input  logic [7:0]    rx_wdata,
  input  logic          rx_fe_in,
  input  logic          rx_pe_in,
  input  logic          rx_pop,
  output logic [7:0]    rx_head,
  output logic          rx_head_fe,
  output logic          rx_head_pe,
  output logic [LW-1:0] rx_level,
  output logic          rx_empty,
  output logic          tx_int,
  output logic          rx_int,
  output logic          rx_ovf
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [2:0]    ctl;
  logic [LW-1:0] tx_thr, rx_thr;
  logic [LW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [7:0]    tx_mem [DEPTH];
  logic [9:0]    rx_mem [DEPTH];

  assign chan_run = ctl[0];
  assign tx_run   = ctl[1];
  assign rx_run   = ctl[2];

  wire tx_hold = ~chan_run | ~tx_run;
  wire rx_hold = ~chan_run | ~rx_run;

  assign tx_level = tx_wp - tx_rp;
  assign rx_level = rx_wp - rx_rp;
  assign tx_empty = (tx_level == '0);
  assign rx_empty = (rx_level == '0);

  wire tx_wr   = tx_push & ~tx_hold & (tx_level != FULL);
  wire tx_rd   = tx_pop  & ~tx_hold & ~tx_empty;
  wire rx_wr   = rx_push & ~rx_hold & (rx_level != FULL);
  wire rx_rd   = rx_pop  & ~rx_hold & ~rx_empty;
  wire rx_drop = rx_push & ~rx_hold & (rx_level == FULL);

  assign tx_head = tx_mem[tx_rp[AW-1:0]];
  assign {rx_head_fe, rx_head_pe, rx_head} = rx_mem[rx_rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= 3'b111;
      tx_thr <= '0;
      rx_thr <= FULL;
    end else begin
      ctl <= (ctl & ~ctl_we) | (ctl_d & ctl_we);
      if (thr_we) begin
        tx_thr <= tx_thr_d;
        rx_thr <= rx_thr_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else if (tx_hold) begin
      tx_wp <= '0;
      tx_rp <= '0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + 1'b1;
      if (tx_rd) tx_rp <= tx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else if (rx_hold) begin
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (rx_wr) rx_wp <= rx_wp + 1'b1;
      if (rx_rd) rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp[AW-1:0]] <= tx_wdata;
    if (rx_wr) rx_mem[rx_wp[AW-1:0]] <= {rx_fe_in, rx_pe_in, rx_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_int <= 1'b0;
      rx_int <= 1'b0;
      rx_ovf <= 1'b0;
    end else if (!chan_run) begin
      tx_int <= 1'b0;
      rx_int <= 1'b0;
      rx_ovf <= 1'b0;
    end else begin
      tx_int <= (tx_int & ~clr_w1c[0]) | (tx_level <= tx_thr);
      rx_int <= (rx_int & ~clr_w1c[1]) | (rx_level >= rx_thr);
      rx_ovf <= (rx_ovf & ~clr_w1c[2]) | rx_drop;
    end
  end
endmodule

// File: rtl/uart_fifo_rstctl_chk.sv
module uart_fifo_rstctl_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    ctl_we,
  input logic [2:0]    ctl_d,
  input logic          chan_run,
  input logic          tx_run,
  input logic          rx_run,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_empty,
  input logic          rx_empty,
  input logic          tx_int,
  input logic          rx_int,
  input logic          rx_ovf
);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  a_r2_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_run |=> (tx_level == '0) && (rx_level == '0) && tx_empty && rx_empty);

  a_r3_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_run |=> !tx_int && !rx_int && !rx_ovf);

  a_r4_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we == 3'b001) |=> $stable(tx_run) && $stable(rx_run));

  a_r5_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run |=> rx_empty);

  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_run |=> tx_empty);

  a_r8_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop && rx_run && chan_run && rx_level == LW'(DEPTH))
      |=> rx_ovf && (rx_level == LW'(DEPTH)));
endmodule

bind uart_fifo_rstctl uart_fifo_rstctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_d(ctl_d),
  .chan_run(chan_run), .tx_run(tx_run), .rx_run(rx_run),
  .rx_push(rx_push), .rx_pop(rx_pop),
  .tx_level(tx_level), .rx_level(rx_level),
  .tx_empty(tx_empty), .rx_empty(rx_empty),
  .tx_int(tx_int), .rx_int(rx_int), .rx_ovf(rx_ovf)
);

// File: tb/tb_uart_fifo_rstctl.sv
module tb_uart_fifo_rstctl;
  localparam int LW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ctl_we = '0, ctl_d = '0, clr_w1c = '0;
  logic thr_we = 1'b0;
  logic [LW-1:0] tx_thr_d = '0, rx_thr_d = '0;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, rx_fe_in = 0, rx_pe_in = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic chan_run, tx_run, rx_run, tx_empty, rx_empty, tx_int, rx_int, rx_ovf;
  logic rx_head_fe, rx_head_pe;
  logic [7:0] tx_head, rx_head;
  logic [LW-1:0] tx_level, rx_level;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_fifo_rstctl dut (.*);

  // {push, pop, data, expected level, expected head, check head}
  localparam logic [23:0] TV [8] = '{
    {1'b1, 1'b0, 8'hA1, 5'd1, 8'hA1, 1'b1},
    {1'b1, 1'b0, 8'hB2, 5'd2, 8'hA1, 1'b1},
    {1'b1, 1'b1, 8'hC3, 5'd2, 8'hB2, 1'b1},
    {1'b0, 1'b1, 8'h00, 5'd1, 8'hC3, 1'b1},
    {1'b1, 1'b0, 8'hD4, 5'd2, 8'hC3, 1'b1},
    {1'b0, 1'b1, 8'h00, 5'd1, 8'hD4, 1'b1},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0},
    {1'b0, 1'b1, 8'h00, 5'd0, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    ctl_we = '0; thr_we = 0; clr_w1c = '0;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; rx_fe_in = 0; rx_pe_in = 0;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic fe, input logic pe);
    rx_push = 1; rx_wdata = d; rx_fe_in = fe; rx_pe_in = pe; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #10;
    chk("R10 levels", {tx_level, rx_level}, '0);
    chk("R10 run bits", {rx_run, tx_run, chan_run}, 3'b111);
    chk("R10 flags", {tx_int, rx_int, rx_ovf}, 3'b000);
    @(negedge clk); rst_n = 1; #1;
    tick();

    for (int i = 0; i < 8; i++) begin
      {tx_push, tx_pop, tx_wdata} = TV[i][23:14];
      tick();
      chk("R1 tx level", tx_level, TV[i][13:9]);
      if (TV[i][0]) chk("R1 tx head", tx_head, TV[i][8:1]);
      else chk("R1 tx empty", tx_empty, 1'b1);
    end

    rx_put(8'h11, 1, 0); rx_put(8'h22, 0, 1); rx_put(8'h33, 0, 0);
    chk("R1 rx level", rx_level, 3);
    chk("R1 rx head", {rx_head_fe, rx_head_pe, rx_head}, {2'b10, 8'h11});

    ctl_we = 3'b100; ctl_d = 3'b000; tick(); tick();
    chk("R5 rx held", {rx_run, rx_empty, rx_level}, {2'b01, 5'd0});
    chk("R7 rx data kept", {rx_head_fe, rx_head_pe, rx_head}, {2'b10, 8'h11});
    rx_put(8'h55, 0, 1);
    chk("R6 rx push ignored", rx_level, 0);
    chk("R6 rx slot untouched", rx_head, 8'h11);
    ctl_we = 3'b100; ctl_d = 3'b100; tick();
    rx_put(8'h66, 1, 1);
    chk("R7 slot overwritten", {rx_level, rx_head_fe, rx_head_pe, rx_head}, {5'd1, 2'b11, 8'h66});

    for (int i = 0; i < 15; i++) rx_put(8'h80 + 8'(i), 0, 0);
    tick();
    chk("R9 rx_int set", rx_int, 1);
    rx_put(8'h77, 0, 0);
    chk("R8 overflow", {rx_ovf, rx_level, rx_head}, {1'b1, 5'd16, 8'h66});

    thr_we = 1; tx_thr_d = 3; rx_thr_d = 16; tick();
    tx_push = 1; tx_wdata = 8'h5A; tick();
    tx_push = 1; tx_wdata = 8'hA5; tick();
    tick();
    chk("R9 tx_int set", {tx_int, tx_level}, {1'b1, 5'd2});

    ctl_we = 3'b001; ctl_d = 3'b000; tick(); tick();
    chk("R2 levels held", {tx_level, rx_level, tx_empty, rx_empty}, {10'd0, 2'b11});
    chk("R3 flags cleared", {tx_int, rx_int, rx_ovf}, 3'b000);
    chk("R4 run bits kept", {rx_run, tx_run, chan_run}, 3'b110);
    chk("R7 tags kept", {rx_head_fe, rx_head_pe, rx_head}, {2'b11, 8'h66});
    chk("R7 tx data kept", tx_head, 8'hA1);
    tx_push = 1; tx_wdata = 8'hEE; tick();
    chk("R6 tx push ignored", tx_level, 0);
    ctl_we = 3'b001; ctl_d = 3'b001; tick();
    chk("R2 released", chan_run, 1);

    thr_we = 1; tx_thr_d = 0; rx_thr_d = 16; tick();
    tx_push = 1; tx_wdata = 8'h3C; tick();
    chk("R4 thresholds kept then rewritten", tx_level, 1);
    clr_w1c = 3'b001; tick();
    chk("R9 tx_int w1c", {tx_int, tx_level}, {1'b0, 5'd1});

    for (int i = 0; i < 17; i++) rx_put(8'h40 + 8'(i), 0, 0);
    chk("R8 overflow again", {rx_ovf, rx_level}, {1'b1, 5'd16});
    clr_w1c = 3'b100; tick();
    chk("R8 ovf w1c", {rx_ovf, rx_level, rx_head}, {1'b0, 5'd16, 8'h40});
    clr_w1c = 3'b010; tick();
    chk("R9 set wins over clear", rx_int, 1);

    finish_run();
  end
endmodule